// File: doc/BRIEF.md
# Incremental Child-Block Allocator

This block holds the memory-block bookkeeping for one process: an instruction pointer, a seek pointer, a primary block (base and size) and a secondary child block (base and size). On each accepted allocation step it examines one cell of a shared per-cell occupancy bitmap at the seek pointer. It then takes one of four actions: it gives up, it reports completion, it grows the child block by that cell, or it backs off after a collision. A controller repeats the allocation command once per execution step until the instruction pointer moves on. Growth runs either upward or downward in the address space. The child block always stays contiguous with the seek pointer.

The same unit also swaps the primary and child blocks, frees the child block, and splits the child block off as the descriptor of a new process. Freeing runs as a walk of one cell per cycle over the bitmap, and `busy` is high for the whole walk. A split presents the new descriptor on a valid/ready handshake and keeps it there until it is taken. All pointer arithmetic wraps modulo 2^ADDR_W.

Top module: `child_alloc_unit`

## Requirements
- R1: After reset, ip, sp, pri_base, pri_size, child_base and child_size are all zero, and busy, res_valid, spawn_valid, bm_set and bm_clr are low.
- R2: An accepted load command (cmd_op = 0) sets ip, sp and pri_base to cmd_addr and pri_size to cmd_size, and clears child_base and child_size.
- R3: An allocation step (cmd_op = 1 for upward, cmd_op = 2 for downward) with cmd_size zero changes only ip, which becomes ip+1, and sp, which is set equal to the new ip. It writes no bitmap cell.
- R4: If child_size is nonzero on an allocation step, sp must equal child_base+child_size (upward) or child_base-1 (downward). If it does not, the step only advances ip and sets sp equal to the new ip, and the child block is left unchanged.
- R5: An adjacent step whose child_size equals cmd_size pulses res_valid for one cycle with res_data = child_base and advances ip as in R3.
- R6: An adjacent step whose cell at sp is free (bm_rdata = 0) sets that cell and increments child_size. child_base becomes sp if the child was empty or the direction is downward. sp then moves one cell in the search direction with wraparound, and ip is unchanged. A cell that is already set is never set.
- R7: An adjacent step whose cell at sp is taken (bm_rdata = 1) clears every cell of the existing child block, one per cycle in ascending address order, and ends with child_base and child_size zero. It keeps busy high for exactly child_size cycles (zero cycles when the child is empty), moves sp one cell in the search direction, and leaves ip unchanged.
- R8: A swap command (cmd_op = 3) exchanges the primary and child base/size pairs only when child_size is nonzero, and always advances ip.
- R9: A clear command (cmd_op = 4) frees a nonzero child block as in R7, ending with the child fields zero, and advances ip.
- R10: A split command (cmd_op = 5) with a nonzero child raises spawn_valid, with spawn_base = child_base and spawn_size = child_size. These are held stable until spawn_ready is sampled high, after which the child fields are zero. The new process starts with ip, seek pointer and primary base at spawn_base. The command advances ip.
- R11: While busy is high, cmd_valid is ignored: no state changes and no bitmap cell is set.
- R12: Op codes 6 and 7 only advance ip and set sp equal to the new ip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; accepted when busy is low |
| cmd_op | input | 3 | Command code (see R2 to R12) |
| cmd_addr | input | ADDR_W | Start address for a load |
| cmd_size | input | ADDR_W | Requested child size, or primary size for a load |
| bm_addr | output | ADDR_W | Bitmap cell address |
| bm_rdata | input | 1 | Occupancy of the cell at bm_addr (combinational) |
| bm_set | output | 1 | Mark the cell at bm_addr as taken |
| bm_clr | output | 1 | Mark the cell at bm_addr as free |
| res_valid | output | 1 | One-cycle write of the result register |
| res_data | output | ADDR_W | Child base reported on completion |
| spawn_valid | output | 1 | New process descriptor offered |
| spawn_ready | input | 1 | Descriptor taken |
| spawn_base | output | ADDR_W | New process ip, seek pointer and primary base |
| spawn_size | output | ADDR_W | New process primary size |
| busy | output | 1 | Free walk or split handshake in progress |
| ip | output | ADDR_W | Instruction pointer |
| sp | output | ADDR_W | Seek pointer |
| pri_base | output | ADDR_W | Primary block base |
| pri_size | output | ADDR_W | Primary block size |
| child_base | output | ADDR_W | Child block base |
| child_size | output | ADDR_W | Child block size |

## Verification
The bench builds the unit with ADDR_W = 6, which gives a 64-cell address space. At that size, growth past address zero in both directions, collisions with cells that the bench marks as foreign, and long free walks all occur often under random stimulus. The small space also makes a full comparison of the bitmap after every command cheap.

// File: rtl/cau_pkg.sv
package cau_pkg;
  localparam logic [2:0] OP_LOAD      = 3'd0;
  localparam logic [2:0] OP_ALLOC_UP  = 3'd1;
  localparam logic [2:0] OP_ALLOC_DN  = 3'd2;
  localparam logic [2:0] OP_SWAP      = 3'd3;
  localparam logic [2:0] OP_CLEAR     = 3'd4;
  localparam logic [2:0] OP_SPLIT     = 3'd5;

  typedef enum logic [1:0] {
    STEP_ADVANCE = 2'd0,
    STEP_DONE    = 2'd1,
    STEP_COLLIDE = 2'd2,
    STEP_GROW    = 2'd3
  } step_t;
endpackage

// File: rtl/cau_alloc_step.sv
module cau_alloc_step
  import cau_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] seek,
  input  logic [ADDR_W-1:0] cbase,
  input  logic [ADDR_W-1:0] csize,
  input  logic [ADDR_W-1:0] want,
  input  logic              upward,
  input  logic              cell_taken,
  output step_t             outcome
);
  // Address the seek pointer must hold for growth to stay contiguous
  function automatic logic [ADDR_W-1:0] grow_edge(input logic [ADDR_W-1:0] b,
                                                  input logic [ADDR_W-1:0] s,
                                                  input logic up);
    return up ? ADDR_W'(b + s) : ADDR_W'(b - ADDR_W'(1));
  endfunction

  logic child_empty;
  logic adjacent;
  assign child_empty = (csize == '0);
  assign adjacent    = child_empty || (seek == grow_edge(cbase, csize, upward));

  always_comb begin
    if (want == '0)          outcome = STEP_ADVANCE;
    else if (!adjacent)      outcome = STEP_ADVANCE;
    else if (csize == want)  outcome = STEP_DONE;
    else if (cell_taken)     outcome = STEP_COLLIDE;
    else                     outcome = STEP_GROW;
  end
endmodule

// File: rtl/cau_free_walker.sv
module cau_free_walker #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_base,
  input  logic [ADDR_W-1:0] start_size,
  output logic              active,
  output logic [ADDR_W-1:0] clr_addr,
  output logic              done
);
  logic [ADDR_W-1:0] base_q, size_q, idx_q;

  assign clr_addr = ADDR_W'(base_q + idx_q);
  assign done     = active && (idx_q == ADDR_W'(size_q - ADDR_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      idx_q  <= '0;
      active <= 1'b0;
    end else if (start) begin
      base_q <= start_base;
      size_q <= start_size;
      idx_q  <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (done) active <= 1'b0;
      else      idx_q  <= idx_q + ADDR_W'(1);
    end
  end

  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
  // R7
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> (active && clr_addr == ADDR_W'($past(clr_addr) + ADDR_W'(1))));
endmodule

// File: rtl/child_alloc_unit.sv
module child_alloc_unit
  import cau_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] cmd_size,
  output logic [ADDR_W-1:0] bm_addr,
  input  logic              bm_rdata,
  output logic              bm_set,
  output logic              bm_clr,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_data,
  output logic              spawn_valid,
  input  logic              spawn_ready,
  output logic [ADDR_W-1:0] spawn_base,
  output logic [ADDR_W-1:0] spawn_size,
  output logic              busy,
  output logic [ADDR_W-1:0] ip,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] pri_base,
  output logic [ADDR_W-1:0] pri_size,
  output logic [ADDR_W-1:0] child_base,
  output logic [ADDR_W-1:0] child_size
);
  function automatic logic [ADDR_W-1:0] seek_next(input logic [ADDR_W-1:0] p,
                                                  input logic up);
    return up ? ADDR_W'(p + ADDR_W'(1)) : ADDR_W'(p - ADDR_W'(1));
  endfunction

  logic              accept, is_alloc, upward, child_live;
  logic              walk_active, walk_done, walk_start;
  logic [ADDR_W-1:0] walk_addr;
  logic              grow_fire, collide_fire, swap_fire, split_fire, spawn_fire;
  logic              spawn_pending;
  step_t             outcome;

  assign busy         = walk_active || spawn_pending;
  assign accept       = cmd_valid && !busy;
  assign is_alloc     = (cmd_op == OP_ALLOC_UP) || (cmd_op == OP_ALLOC_DN);
  assign upward       = (cmd_op == OP_ALLOC_UP);
  assign child_live   = (child_size != '0);
  assign grow_fire    = accept && is_alloc && (outcome == STEP_GROW);
  assign collide_fire = accept && is_alloc && (outcome == STEP_COLLIDE);
  assign swap_fire    = accept && (cmd_op == OP_SWAP) && child_live;
  assign split_fire   = accept && (cmd_op == OP_SPLIT) && child_live;
  assign spawn_fire   = spawn_valid && spawn_ready;
  assign walk_start   = child_live &&
                        (collide_fire || (accept && cmd_op == OP_CLEAR));

  assign bm_addr     = walk_active ? walk_addr : sp;
  assign bm_set      = grow_fire;
  assign bm_clr      = walk_active;
  assign spawn_valid = spawn_pending;
  assign spawn_base  = child_base;
  assign spawn_size  = child_size;

  cau_alloc_step #(.ADDR_W(ADDR_W)) i_step (
    .seek(sp), .cbase(child_base), .csize(child_size), .want(cmd_size),
    .upward(upward), .cell_taken(bm_rdata), .outcome(outcome)
  );

  cau_free_walker #(.ADDR_W(ADDR_W)) i_walk (
    .clk(clk), .rst_n(rst_n), .start(walk_start), .start_base(child_base),
    .start_size(child_size), .active(walk_active), .clr_addr(walk_addr),
    .done(walk_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip <= '0; sp <= '0; pri_base <= '0; pri_size <= '0;
      child_base <= '0; child_size <= '0;
      res_valid <= 1'b0; res_data <= '0; spawn_pending <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (walk_done || spawn_fire) begin
        child_base <= '0;
        child_size <= '0;
      end
      if (spawn_fire) spawn_pending <= 1'b0;
      if (accept) begin
        if (cmd_op == OP_LOAD) begin
          ip <= cmd_addr; sp <= cmd_addr; pri_base <= cmd_addr;
          pri_size <= cmd_size; child_base <= '0; child_size <= '0;
        end else if (is_alloc && outcome == STEP_COLLIDE) begin
          sp <= seek_next(sp, upward);
        end else if (is_alloc && outcome == STEP_GROW) begin
          child_size <= child_size + ADDR_W'(1);
          if (!child_live || !upward) child_base <= sp;
          sp <= seek_next(sp, upward);
        end else begin
          ip <= ip + ADDR_W'(1);
          sp <= ip + ADDR_W'(1);
          if (is_alloc && outcome == STEP_DONE) begin
            res_valid <= 1'b1;
            res_data  <= child_base;
          end
          if (swap_fire) begin
            pri_base <= child_base; pri_size <= child_size;
            child_base <= pri_base; child_size <= pri_size;
          end
          if (split_fire) spawn_pending <= 1'b1;
        end
      end
    end
  end

  // R6
  grow_free_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bm_set |-> !bm_rdata);
  // R6
  grow_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bm_set |=> child_size == ADDR_W'($past(child_size) + ADDR_W'(1)));
  // R7
  free_end_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> (child_size == '0 && child_base == '0));
  // R8
  swap_exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |=> (pri_base == $past(child_base) && pri_size == $past(child_size)
                   && child_base == $past(pri_base)));
  // R10
  spawn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spawn_valid && !spawn_ready) |=> (spawn_valid && $stable(spawn_base)
                                       && $stable(spawn_size)));
  // R11
  no_set_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !bm_set);
  // R5
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

// File: tb/test_child_alloc_unit.sv
module test_child_alloc_unit;
  localparam int AW = 6;
  localparam int CELLS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0, cmd_size = '0;
  logic [AW-1:0] bm_addr;
  logic bm_rdata, bm_set, bm_clr;
  logic res_valid, spawn_valid, busy;
  logic spawn_ready = 1'b0;
  logic [AW-1:0] res_data, spawn_base, spawn_size;
  logic [AW-1:0] ip, sp, pri_base, pri_size, child_base, child_size;

  always #2 clk = ~clk;

  child_alloc_unit #(.ADDR_W(AW)) i_child_alloc_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .bm_addr(bm_addr),
    .bm_rdata(bm_rdata), .bm_set(bm_set), .bm_clr(bm_clr),
    .res_valid(res_valid), .res_data(res_data), .spawn_valid(spawn_valid),
    .spawn_ready(spawn_ready), .spawn_base(spawn_base), .spawn_size(spawn_size),
    .busy(busy), .ip(ip), .sp(sp), .pri_base(pri_base), .pri_size(pri_size),
    .child_base(child_base), .child_size(child_size)
  );

  // Shared bitmap; the bench can poke foreign cells between commands
  logic mem [CELLS];
  logic poke_en = 1'b0, poke_val = 1'b0;
  logic [AW-1:0] poke_addr = '0;
  assign bm_rdata = mem[bm_addr];
  initial for (int i = 0; i < CELLS; i++) mem[i] = 1'b0;
  always @(posedge clk) begin
    if (bm_set) mem[bm_addr] <= 1'b1;
    if (bm_clr) mem[bm_addr] <= 1'b0;
    if (poke_en) mem[poke_addr] <= poke_val;
  end

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      wrap_up();
    end
  end

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model state
  logic [AW-1:0] m_ip = '0, m_sp = '0, m_pb = '0, m_ps = '0, m_cb = '0, m_cs = '0;
  logic exp_mem [CELLS];
  initial for (int i = 0; i < CELLS; i++) exp_mem[i] = 1'b0;
  bit e_res, e_spawn;
  logic [AW-1:0] e_res_data, e_sb, e_ss;
  int e_busy;

  function automatic logic [AW-1:0] move(input logic [AW-1:0] p, input bit up);
    return up ? AW'(p + 1) : AW'(p - 1);
  endfunction

  task automatic model(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [AW-1:0] s, output string tag);
    bit adv = 1;
    bit up;
    logic [AW-1:0] want_sp;
    e_res = 0; e_spawn = 0; e_busy = 0; tag = "R12";
    case (op)
      3'd0: begin
        tag = "R2"; adv = 0;
        m_ip = a; m_sp = a; m_pb = a; m_ps = s; m_cb = '0; m_cs = '0;
      end
      3'd1, 3'd2: begin
        up = (op == 3'd1);
        want_sp = up ? AW'(m_cb + m_cs) : AW'(m_cb - 1);
        if (s == 0) tag = "R3";
        else if (m_cs != 0 && m_sp != want_sp) tag = "R4";
        else if (m_cs == s) begin
          tag = "R5"; e_res = 1; e_res_data = m_cb;
        end else if (exp_mem[m_sp]) begin
          tag = "R7"; adv = 0; e_busy = m_cs;
          for (int i = 0; i < m_cs; i++) exp_mem[AW'(m_cb + AW'(i))] = 1'b0;
          m_cb = '0; m_cs = '0; m_sp = move(m_sp, up);
        end else begin
          tag = "R6"; adv = 0; exp_mem[m_sp] = 1'b1;
          if (m_cs == 0 || !up) m_cb = m_sp;
          m_cs = m_cs + 1; m_sp = move(m_sp, up);
        end
      end
      3'd3: begin
        tag = "R8";
        if (m_cs != 0) begin
          {m_pb, m_cb} = {m_cb, m_pb};
          {m_ps, m_cs} = {m_cs, m_ps};
        end
      end
      3'd4: begin
        tag = "R9"; e_busy = m_cs;
        for (int i = 0; i < m_cs; i++) exp_mem[AW'(m_cb + AW'(i))] = 1'b0;
        m_cb = '0; m_cs = '0;
      end
      3'd5: begin
        tag = "R10";
        if (m_cs != 0) begin
          e_spawn = 1; e_sb = m_cb; e_ss = m_cs; m_cb = '0; m_cs = '0;
        end
      end
      default: ;
    endcase
    if (adv) begin m_ip = m_ip + 1; m_sp = m_ip; end
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic v);
    @(negedge clk);
    poke_en = 1; poke_addr = a; poke_val = v; exp_mem[a] = v;
    @(negedge clk);
    poke_en = 0;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [AW-1:0] s, input int hold);
    string tag;
    int n, bad;
    model(op, a, s, tag);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_size = s;
    @(negedge clk);
    // Keep presenting an ignored command while busy (R11)
    cmd_op = 3'd7; cmd_valid = busy;
    chk(tag, "res_valid", res_valid, e_res);
    if (e_res) chk("R5", "res_data", res_data, e_res_data);
    if (e_spawn) begin
      chk("R10", "spawn_valid", spawn_valid, 1);
      chk("R10", "spawn_base", spawn_base, e_sb);
      chk("R10", "spawn_size", spawn_size, e_ss);
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk("R10", "spawn held", spawn_valid, 1);
        chk("R10", "spawn_base held", spawn_base, e_sb);
      end
      spawn_ready = 1;
      @(negedge clk);
      spawn_ready = 0; cmd_valid = 0;
    end
    n = 0;
    while (busy && n < 200) begin
      n++;
      cmd_valid = 1;
      @(negedge clk);
    end
    cmd_valid = 0;
    if (!e_spawn) chk(tag, "busy cycles", n, e_busy);
    chk(tag, "spawn_valid idle", spawn_valid, 0);
    chk(tag, "ip (R11 ignored cmds)", ip, m_ip);
    chk(tag, "sp", sp, m_sp);
    chk(tag, "pri_base", pri_base, m_pb);
    chk(tag, "pri_size", pri_size, m_ps);
    chk(tag, "child_base", child_base, m_cb);
    chk(tag, "child_size", child_size, m_cs);
    bad = 0;
    for (int i = 0; i < CELLS; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(tag, "bitmap mismatches", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ip", ip, 0); chk("R1", "sp", sp, 0);
    chk("R1", "child_size", child_size, 0); chk("R1", "pri_size", pri_size, 0);
    chk("R1", "busy", busy, 0); chk("R1", "spawn_valid", spawn_valid, 0);
    chk("R1", "res_valid", res_valid, 0); chk("R1", "bm_set", bm_set, 0);
    rst_n = 1;
    // R2 load, R3 zero size
    run_cmd(3'd0, 6'd10, 6'd3, 0);
    run_cmd(3'd1, 6'd0, 6'd0, 0);
    // R6 grow upward three cells, then R5 completion
    for (int k = 0; k < 4; k++) run_cmd(3'd1, 6'd0, 6'd3, 0);
    // R4 downward not adjacent
    run_cmd(3'd2, 6'd0, 6'd5, 0);
    // R9 clear
    run_cmd(3'd4, 6'd0, 6'd0, 0);
    // R7 collision with a foreign cell after two grown cells
    poke(6'd16, 1'b1);
    for (int k = 0; k < 8; k++) run_cmd(3'd1, 6'd0, 6'd4, 0);
    // R8 swap, R10 split with stall, R8 swap with empty child
    run_cmd(3'd3, 6'd0, 6'd0, 0);
    run_cmd(3'd5, 6'd0, 6'd0, 2);
    run_cmd(3'd3, 6'd0, 6'd0, 0);
    // R6 downward growth wrapping below zero
    run_cmd(3'd0, 6'd1, 6'd1, 0);
    for (int k = 0; k < 4; k++) run_cmd(3'd2, 6'd0, 6'd3, 0);
    // R12 unused op codes
    run_cmd(3'd6, 6'd0, 6'd0, 0);
    run_cmd(3'd7, 6'd0, 6'd0, 0);
    // Random mix
    for (int it = 0; it < 3000; it++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) poke(AW'($urandom), 1'b1);
      else if (r < 5) poke(AW'($urandom), 1'b0);
      else if (r < 9) run_cmd(3'd0, AW'($urandom), AW'($urandom_range(1, 6)), 0);
      else if (r < 74) run_cmd($urandom_range(0, 1) ? 3'd1 : 3'd2, '0,
                               AW'($urandom_range(0, 5)), 0);
      else run_cmd(3'($urandom_range(3, 7)), '0, '0, $urandom_range(0, 2));
    end
    wrap_up();
  end
endmodule